// File: doc/BRIEF.md
# SDRAM Address Mapper and Open-Page Tracker

This block sits between a processor's flat word address and the multiplexed address pins of an SDRAM. It splits each address into column, bank and row fields under one of six geometries: a page of 256, 512 or 1024 words, with either two or four internal banks. Column bits are always the lowest address bits. The bank bits sit directly above them, and the row bits sit above the bank bits. When a command sequencer asks for it, the block drives the row onto the SDRAM address lines for an activate, the column for a read or write, and the all-bank select pattern for a precharge.

The block also remembers the one row, in the one bank, that is currently open. Only a single bank may be open at any time. For this reason an access to another bank is reported exactly like an access to another row: as a page miss that forces a precharge and a new activate. Every column of the open page is a hit, including the circular step from the last column back to column 0. The sequencer uses the hit and miss flags to decide between a one-cycle access and the full precharge and activate path.

The geometry inputs are followed only while no row is open. While a row is open the geometry is frozen, and a new geometry takes effect once a precharge has closed the row.

Top module: `sdram_addr_mapper`

## Requirements
- R1: After reset, `sd_addr` is 0, both flags are low and no row is open, so the first access is always a miss.
- R2: Page code `cfg_page_sel` of 0, 1 or 2 (3 behaves as 2) gives a column width `cw` of 8, 9 or 10. On a read/write command (`cmd_sel`=2), `sd_addr[cw-1:0]` equals `acc_addr[cw-1:0]` of the last access, `sd_addr` bits 11..cw are 0 (line 10 is therefore low), and the bank lines match the activate layout.
- R3: In a two-bank geometry (`cfg_four_bank`=0), an activate (`cmd_sel`=1) drives `acc_addr[cw]` on line 13 and `acc_addr[cw+11:cw+1]` on lines 10:0. Lines 12 and 11 are 0.
- R4: In a four-bank geometry, an activate drives `acc_addr[cw+1:cw]` on lines 13:12 and `acc_addr[cw+13:cw+2]` on lines 11:0.
- R5: A precharge-all command (`cmd_sel`=3) drives `sd_addr`=0x0400 (only line 10 high) and closes the open row. The next access is then a miss.
- R6: A no-operation command (`cmd_sel`=0) drives `sd_addr`=0.
- R7: One cycle after `acc_valid` is high, exactly one of `acc_hit` and `acc_miss` is high. Both are low one cycle after `acc_valid` is low. A hit means a row is open and the access has the same row and bank.
- R8: An access to the open row number in a different bank is a miss. That bank and row then become the open page.
- R9: Within the open page, an access to column 0 that follows an access to the last column is a hit.
- R10: While a row is open, changes to `cfg_page_sel` and `cfg_four_bank` have no effect on the field split or on the `sd_addr` layout. After a precharge, the new geometry applies.
- R11: An access in the same cycle as a precharge-all is a miss, and its page becomes the open page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Processor access strobe |
| acc_addr | input | ADDR_W | Flat word address of the access |
| cfg_page_sel | input | 2 | Page size code: 0=256, 1=512, 2/3=1024 words |
| cfg_four_bank | input | 1 | 1 = four banks, 0 = two banks |
| cmd_sel | input | 2 | 0 NOP, 1 activate, 2 read/write, 3 precharge all |
| sd_addr | output | 14 | Multiplexed SDRAM address, bank lines on 13:12 |
| acc_hit | output | 1 | Access falls in the open page |
| acc_miss | output | 1 | Access needs precharge and activate |

## Verification
A corrupted open-page record shows up on the first access after the corruption: a hit appears where a miss is due, or the reverse, one cycle after the strobe. The same fault also shows as a wrong row on the next activate. A wrong geometry decode, or a geometry that is not properly frozen, moves bits between the bank, row and column fields. This appears in the very next activate or read/write word. For that reason the bench sweeps every geometry with addresses that touch the page, bank and wrap boundaries, and compares each output word, one cycle after its command, with fields computed arithmetically.

// File: rtl/sdmap_pkg.sv
package sdmap_pkg;
  localparam int SDA_W     = 14;
  localparam int BANK_W    = 2;
  localparam int COL_W_MIN = 8;
  localparam int N_PAGE    = 3;
  localparam int PG_W      = 2;
  localparam int COL_W_MAX = COL_W_MIN + N_PAGE - 1;
  localparam int ROW_W_4B  = 12;
  localparam int ROW_W_2B  = 11;
  localparam int LOW_W     = SDA_W - BANK_W;
  localparam int ALL_BIT   = 10;
  localparam int MIN_ADDR_W = COL_W_MAX + BANK_W + ROW_W_4B;

  typedef enum logic [1:0] {
    CMD_NOP  = 2'd0,
    CMD_ACT  = 2'd1,
    CMD_RW   = 2'd2,
    CMD_PREA = 2'd3
  } sd_cmd_e;

  typedef struct packed {
    logic [PG_W-1:0] pg;
    logic            four_bank;
  } geom_t;

  typedef struct packed {
    logic [ROW_W_4B-1:0]  row;
    logic [BANK_W-1:0]    bank;
    logic [COL_W_MAX-1:0] col;
  } sd_fields_t;
endpackage

// File: rtl/sdmap_split.sv
module sdmap_split
  import sdmap_pkg::*;
#(
  parameter int ADDR_W = MIN_ADDR_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  geom_t             geom,
  output sd_fields_t        fields
);
  sd_fields_t cand2 [N_PAGE];
  sd_fields_t cand4 [N_PAGE];
  logic [PG_W-1:0] pidx;

  for (genvar p = 0; p < N_PAGE; p++) begin : g_pg
    localparam int CW = COL_W_MIN + p;
    sd_fields_t f2, f4;
    always_comb begin
      f2 = '0;
      f2.col[CW-1:0]       = addr[CW-1:0];
      f2.bank[0]           = addr[CW];
      f2.row[ROW_W_2B-1:0] = addr[CW+ROW_W_2B:CW+1];
      f4 = '0;
      f4.col[CW-1:0]       = addr[CW-1:0];
      f4.bank              = addr[CW+BANK_W-1:CW];
      f4.row               = addr[CW+BANK_W+ROW_W_4B-1:CW+BANK_W];
    end
    assign cand2[p] = f2;
    assign cand4[p] = f4;
  end

  // Unused code 3 falls back to the widest page
  assign pidx   = (geom.pg > PG_W'(N_PAGE-1)) ? PG_W'(N_PAGE-1) : geom.pg;
  assign fields = geom.four_bank ? cand4[pidx] : cand2[pidx];
endmodule

// File: rtl/sdmap_tracker.sv
module sdmap_tracker
  import sdmap_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       acc_valid,
  input  logic       prea,
  input  geom_t      geom_in,
  input  sd_fields_t fields,
  output geom_t      geom_eff,
  output sd_fields_t rec,
  output logic       rec_four_bank,
  output logic       hit,
  output logic       miss
);
  logic  open_q;
  geom_t geom_q;
  logic  match;

  // Geometry follows the inputs only while no page is open
  assign geom_eff = open_q ? geom_q : geom_in;
  assign match    = open_q && !prea && (rec.row == fields.row) && (rec.bank == fields.bank);

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q        <= 1'b0;
      geom_q        <= '0;
      rec           <= '0;
      rec_four_bank <= 1'b0;
      hit           <= 1'b0;
      miss          <= 1'b0;
    end else begin
      hit  <= acc_valid && match;
      miss <= acc_valid && !match;
      if (!open_q) geom_q <= geom_in;
      if (acc_valid) begin
        open_q        <= 1'b1;
        rec           <= fields;
        rec_four_bank <= geom_eff.four_bank;
      end else if (prea) begin
        open_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sdmap_addr_fmt.sv
module sdmap_addr_fmt
  import sdmap_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  sd_cmd_e          cmd,
  input  sd_fields_t       rec,
  input  logic             four_bank,
  output logic [SDA_W-1:0] sd_addr
);
  logic [BANK_W-1:0] bank_lines;
  logic [LOW_W-1:0]  row_low, col_low;
  logic [SDA_W-1:0]  nxt;

  always_comb begin
    bank_lines = four_bank ? rec.bank : {rec.bank[0], 1'b0};
    row_low    = '0;
    if (four_bank) row_low = rec.row;
    else           row_low[ROW_W_2B-1:0] = rec.row[ROW_W_2B-1:0];
    col_low    = '0;
    col_low[COL_W_MAX-1:0] = rec.col;
    unique case (cmd)
      CMD_ACT:  nxt = {bank_lines, row_low};
      CMD_RW:   nxt = {bank_lines, col_low};
      CMD_PREA: nxt = SDA_W'(1) << ALL_BIT;
      default:  nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) sd_addr <= '0;
    else     sd_addr <= nxt;
  end
endmodule

// File: rtl/sdram_addr_mapper.sv
module sdram_addr_mapper
  import sdmap_pkg::*;
#(
  parameter int ADDR_W = MIN_ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        cfg_page_sel,
  input  logic              cfg_four_bank,
  input  logic [1:0]        cmd_sel,
  output logic [13:0]       sd_addr,
  output logic              acc_hit,
  output logic              acc_miss
);
  sd_cmd_e    cmd;
  geom_t      geom_in, geom_eff;
  sd_fields_t fields, rec;
  logic       rec_four_bank;

  assign cmd     = sd_cmd_e'(cmd_sel);
  assign geom_in = '{pg: cfg_page_sel, four_bank: cfg_four_bank};

  sdmap_split #(.ADDR_W(ADDR_W)) i_split (
    .addr   (acc_addr),
    .geom   (geom_eff),
    .fields (fields)
  );

  sdmap_tracker i_track (
    .clk           (clk),
    .rst           (rst),
    .acc_valid     (acc_valid),
    .prea          (cmd == CMD_PREA),
    .geom_in       (geom_in),
    .fields        (fields),
    .geom_eff      (geom_eff),
    .rec           (rec),
    .rec_four_bank (rec_four_bank),
    .hit           (acc_hit),
    .miss          (acc_miss)
  );

  sdmap_addr_fmt i_fmt (
    .clk       (clk),
    .rst       (rst),
    .cmd       (cmd),
    .rec       (rec),
    .four_bank (rec_four_bank),
    .sd_addr   (sd_addr)
  );
endmodule

// File: rtl/sdmap_checker.sv
module sdmap_checker (
  input logic        clk,
  input logic        rst,
  input logic        acc_valid,
  input logic [1:0]  cmd_sel,
  input logic [13:0] sd_addr,
  input logic        acc_hit,
  input logic        acc_miss
);
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) !(acc_hit && acc_miss)); // R7
  AST_FLAG_ON_ACCESS: assert property (@(posedge clk) disable iff (rst) acc_valid |=> (acc_hit || acc_miss)); // R7
  AST_NO_FLAG_IDLE: assert property (@(posedge clk) disable iff (rst) !acc_valid |=> (!acc_hit && !acc_miss)); // R7
  AST_PREA_PATTERN: assert property (@(posedge clk) disable iff (rst) (cmd_sel == 2'd3) |=> (sd_addr == 14'h0400)); // R5
  AST_NOP_QUIET: assert property (@(posedge clk) disable iff (rst) (cmd_sel == 2'd0) |=> (sd_addr == 14'h0000)); // R6
  AST_RW_LINE10_LOW: assert property (@(posedge clk) disable iff (rst) (cmd_sel == 2'd2) |=> (sd_addr[11:10] == 2'b00)); // R2
  AST_MISS_AFTER_PREA: assert property (@(posedge clk) disable iff (rst) (acc_valid && $past(cmd_sel == 2'd3) && $past(!acc_valid)) |=> acc_miss); // R5
  AST_MISS_WITH_PREA: assert property (@(posedge clk) disable iff (rst) (acc_valid && cmd_sel == 2'd3) |=> acc_miss); // R11
endmodule

bind sdram_addr_mapper sdmap_checker i_sdmap_checker (
  .clk       (clk),
  .rst       (rst),
  .acc_valid (acc_valid),
  .cmd_sel   (cmd_sel),
  .sd_addr   (sd_addr),
  .acc_hit   (acc_hit),
  .acc_miss  (acc_miss)
);

// File: tb/test_sdram_addr_mapper.sv
module test_sdram_addr_mapper;
  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rst;
  logic          acc_valid;
  logic [AW-1:0] acc_addr;
  logic [1:0]    cfg_page_sel;
  logic          cfg_four_bank;
  logic [1:0]    cmd_sel;
  logic [13:0]   sd_addr;
  logic          acc_hit, acc_miss;

  int n_chk = 0;
  int n_bad = 0;
  bit m_open;
  int m_row, m_bank;

  always #2.5 clk = ~clk;

  sdram_addr_mapper #(.ADDR_W(AW)) i_sdram_addr_mapper (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .cfg_page_sel(cfg_page_sel), .cfg_four_bank(cfg_four_bank),
    .cmd_sel(cmd_sel), .sd_addr(sd_addr), .acc_hit(acc_hit), .acc_miss(acc_miss)
  );

  function automatic int colw(int pg);
    return (pg >= 2) ? 10 : 8 + pg;
  endfunction
  function automatic int f_col(int a, int pg);
    return a % (1 << colw(pg));
  endfunction
  function automatic int f_bank(int a, int pg, int nb4);
    return (a >> colw(pg)) % (nb4 ? 4 : 2);
  endfunction
  function automatic int f_row(int a, int pg, int nb4);
    return nb4 ? (a >> (colw(pg) + 2)) % 4096 : (a >> (colw(pg) + 1)) % 2048;
  endfunction
  function automatic int exp_act(int a, int pg, int nb4);
    return nb4 ? f_bank(a, pg, 1) * 4096 + f_row(a, pg, 1)
               : f_bank(a, pg, 0) * 8192 + f_row(a, pg, 0);
  endfunction
  function automatic int exp_rw(int a, int pg, int nb4);
    return (nb4 ? f_bank(a, pg, 1) * 4096 : f_bank(a, pg, 0) * 8192) + f_col(a, pg);
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Each task starts and ends at a falling edge
  task automatic access(int a, bit with_prea, int exp_hit, string req);
    acc_valid = 1'b1;
    acc_addr  = AW'(a);
    cmd_sel   = with_prea ? 2'd3 : 2'd0;
    @(negedge clk);
    acc_valid = 1'b0;
    cmd_sel   = 2'd0;
    chk(req, {30'd0, acc_hit, acc_miss}, exp_hit ? 2 : 1);
  endtask

  task automatic command(logic [1:0] c, int exp, string req);
    cmd_sel = c;
    @(negedge clk);
    cmd_sel = 2'd0;
    chk(req, int'(sd_addr), exp);
  endtask

  // Bench model of the open page under geometry pg/nb4
  task automatic model_access(int a, int pg, int nb4, string req);
    int h;
    h = (m_open && f_row(a, pg, nb4) == m_row && f_bank(a, pg, nb4) == m_bank) ? 1 : 0;
    access(a, 1'b0, h, req);
    m_open = 1; m_row = f_row(a, pg, nb4); m_bank = f_bank(a, pg, nb4);
    command(2'd1, exp_act(a, pg, nb4), nb4 ? "R4 activate layout" : "R3 activate layout");
    command(2'd2, exp_rw(a, pg, nb4), "R2 column layout");
    @(negedge clk);
    chk("R6 nop output", int'(sd_addr), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int a, prev, r, cm;
    rst = 1'b1; acc_valid = 1'b0; acc_addr = '0;
    cfg_page_sel = 2'd0; cfg_four_bank = 1'b0; cmd_sel = 2'd0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset sd_addr", int'(sd_addr), 0);
    chk("R1 reset flags", {30'd0, acc_hit, acc_miss}, 0);
    access(24'h00ABCD, 1'b0, 0, "R1 first access misses");
    command(2'd3, 32'h400, "R5 precharge pattern");

    // Sweep every geometry, including unused page code 3
    for (int g = 0; g < 8; g++) begin
      int pg, nb4;
      pg = g / 2; nb4 = g % 2;
      cfg_page_sel = 2'(pg); cfg_four_bank = nb4[0];
      command(2'd3, 32'h400, "R5 precharge pattern");
      m_open = 0;
      cm = (1 << colw(pg)) - 1;
      prev = 0;
      for (int i = 0; i < 30; i++) begin
        r = ((i + 1) * 32'h9E3779B1 + g * 32'h7F4A7C15) >>> 7;
        r = r & 32'hFFFFFF;
        case (i % 5)
          0: a = r;
          1: a = (prev & ~cm) | (r & cm);
          2: a = prev ^ (1 << colw(pg));
          3: a = prev | cm;
          default: a = prev & ~cm;
        endcase
        a = a & 32'hFFFFFF;
        if (i % 5 == 2) model_access(a, pg, nb4, "R8 other bank misses");
        else if (i % 5 == 4) model_access(a, pg, nb4, "R9 wrap to column 0 hits");
        else model_access(a, pg, nb4, "R7 hit/miss classification");
        prev = a;
        if (i % 7 == 6) begin
          command(2'd3, 32'h400, "R5 precharge pattern");
          m_open = 0;
          model_access(a, pg, nb4, "R5 access after precharge misses");
        end
      end
    end

    // R10 geometry frozen while a row is open
    command(2'd3, 32'h400, "R5 precharge pattern");
    cfg_page_sel = 2'd0; cfg_four_bank = 1'b0;
    @(negedge clk);
    access(32'h001234, 1'b0, 0, "R10 open under small geometry");
    cfg_page_sel = 2'd2; cfg_four_bank = 1'b1;
    @(negedge clk);
    access(32'h001235, 1'b0, 1, "R10 change ignored while open");
    command(2'd2, exp_rw(32'h001235, 0, 0), "R10 frozen column layout");
    command(2'd1, exp_act(32'h001235, 0, 0), "R10 frozen activate layout");
    command(2'd3, 32'h400, "R5 precharge pattern");
    @(negedge clk);
    access(32'h001235, 1'b0, 0, "R10 new geometry after precharge");
    command(2'd2, exp_rw(32'h001235, 2, 1), "R10 new column layout");
    command(2'd1, exp_act(32'h001235, 2, 1), "R10 new activate layout");

    // R11 access together with precharge
    access(32'h001236, 1'b0, 1, "R11 same page before");
    access(32'h001237, 1'b1, 0, "R11 access with precharge misses");
    chk("R11 precharge pattern", int'(sd_addr), 32'h400);
    access(32'h001238, 1'b0, 1, "R11 page kept after precharge");
    access(32'h801238, 1'b0, 0, "R7 other row misses");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule